// File: doc/BRIEF.md
# Serial Command Register Interface

A slave-side serial host port that gives a host read and write access to a small bank of 8-bit command registers over four wires: an active-low chip select, a serial clock, serial data in and serial data out. The bank serves four channel groups. Each group owns one read/write control register holding six mode bits, which drive the channel's datapath, and one read-only status register reporting that channel's lock flag, which comes from an external input.

Each access is one frame of sixteen serial clocks. The host first sends an operation bit, then a seven-bit address, then eight data bits. Address and data both go least significant bit first. On a read the block turns its output driver on partway through the frame and shifts the register contents out on falling edges. On a write the byte is committed only when the sixteenth rising edge arrives. Raising chip select early abandons the frame. All logic runs on the serial clock. Chip select acts as an asynchronous clear for the frame state.

Top module: `sci_regbank`

## Requirements
- R1: While `rst_n` is low, every control register reads as 0 on `mode_bits` and `sdo_oe` is low.
- R2: A 16-clock write frame sets the six mode bits of channel c to D5..D0 of the data byte. The frame is: SDI bit 1 = 0 (write), bits 2..8 = address A0..A6, bits 9..16 = D0..D7. The address has A4:A3 = c, A2:A0 = 6 and A5 = 0. `mode_bits[6c+5:6c]` then shows the value, and a read of the same address returns it with D7:D6 = 0.
- R3: The write takes effect only on the sixteenth rising edge of the frame. A frame cut short by raising `cs_n` changes no register, and the next full frame works normally.
- R4: An access with A5 = 1 has no effect on a write and returns 0x00 on a read.
- R5: The value of A6 has no effect on decoding.
- R6: Writes to a status slot (A2:A0 = 7) or to any slot other than 6 and 7 change no register.
- R7: On a read frame (SDI bit 1 = 1), `sdo_oe` is low through the eighth rising edge. It rises on the following falling edge. SDO then presents D0..D7 in order, one bit per falling edge, each valid at the next rising edge. `sdo_oe` falls on the falling edge after the sixteenth rising edge.
- R8: Reading slot 7 of channel c returns `lock_in[c]` in D0 and 0 in D7..D1. The flag is sampled when the read data is launched.
- R9: Reading an unmapped slot returns 0x00.
- R10: `sdo_oe` is low whenever `cs_n` is high and throughout every write frame. While `sdo_oe` is low, `sdo` is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the register bank |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select; high clears the frame state |
| sdi | input | 1 | Serial data from the host, sampled on rising edges |
| lock_in | input | NCH | Per-channel lock flags shown in the status registers |
| sdo | output | 1 | Serial read data, launched on falling edges, high-impedance when idle |
| sdo_oe | output | 1 | High while `sdo` is being driven |
| mode_bits | output | NCH*MODE_W | Six mode bits per channel, channel 0 in the lowest bits |

## Verification
The hardest case to reach is an abandoned frame. Chip select has to rise after the data bits have started to shift in, but before the commit edge. The frame state must then clear without any register update. The bench cuts write frames after 12 and after 15 clocks, the latter one edge short of the commit. It then reads the register back and follows with a full write to show the port recovers. Reads are scored against a model queue, so that launch-edge timing and bit order are checked bit by bit.

// File: rtl/sci_pkg.sv
package sci_pkg;

  localparam int DATA_W      = 8;
  localparam int ADDR_USED_W = 6;            // A0..A5 kept, A6 dropped
  localparam int HDR_LEN     = 8;            // op bit plus seven address bits
  localparam int FRAME_LEN   = HDR_LEN + DATA_W;
  localparam int CNT_W       = $clog2(FRAME_LEN + 1);
  localparam int CH_LSB      = 3;
  localparam int CH_W        = 2;

  localparam logic [2:0] SLOT_CTRL = 3'd6;
  localparam logic [2:0] SLOT_STAT = 3'd7;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_CTRL,
    ACC_STAT
  } acc_kind_e;

  typedef struct packed {
    logic                   rd;
    logic [ADDR_USED_W-1:0] addr;
  } frame_hdr_t;

  function automatic acc_kind_e classify(input logic [ADDR_USED_W-1:0] addr,
                                         input int nch);
    acc_kind_e k;
    k = ACC_NONE;
    if (!addr[5] && (int'(addr[CH_LSB +: CH_W]) < nch)) begin
      case (addr[2:0])
        SLOT_CTRL: k = ACC_CTRL;
        SLOT_STAT: k = ACC_STAT;
        default:   k = ACC_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/sci_frame_ctr.sv
module sci_frame_ctr
  import sci_pkg::*;
(
  input  logic              sclk,
  input  logic              frame_rst_n,
  input  logic              sdi,
  output logic [CNT_W-1:0]  bit_cnt,
  output frame_hdr_t        hdr,
  output logic [DATA_W-1:0] wr_byte,
  output logic              wr_fire
);

  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   cnt_en;
  logic                   rd_q, rd_d, rd_en;
  logic [ADDR_USED_W-1:0] addr_q, addr_d;
  logic                   addr_en;
  logic [DATA_W-2:0]      dsr_q, dsr_d;
  logic                   dsr_en;

  always_comb begin
    cnt_en  = (cnt_q != CNT_W'(FRAME_LEN));
    cnt_d   = cnt_q + CNT_W'(1);
    rd_en   = (cnt_q == '0);
    rd_d    = sdi;
    addr_en = (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(ADDR_USED_W));
    addr_d  = {sdi, addr_q[ADDR_USED_W-1:1]};
    dsr_en  = (cnt_q >= CNT_W'(HDR_LEN)) && (cnt_q < CNT_W'(FRAME_LEN - 1));
    dsr_d   = {sdi, dsr_q[DATA_W-2:1]};
  end

  always_ff @(posedge sclk or negedge frame_rst_n) begin
    if (!frame_rst_n) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      dsr_q  <= '0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (rd_en)   rd_q   <= rd_d;
      if (addr_en) addr_q <= addr_d;
      if (dsr_en)  dsr_q  <= dsr_d;
    end
  end

  // Commit happens on the edge that samples the final data bit.
  assign wr_fire  = !rd_q && (cnt_q == CNT_W'(FRAME_LEN - 1));
  assign wr_byte  = {sdi, dsr_q};
  assign bit_cnt  = cnt_q;
  assign hdr.rd   = rd_q;
  assign hdr.addr = addr_q;

endmodule

// File: rtl/sci_regfile.sv
module sci_regfile
  import sci_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int MODE_W = 6
) (
  input  logic                   sclk,
  input  logic                   rst_n,
  input  logic                   wr_fire,
  input  logic [ADDR_USED_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]      wr_byte,
  input  logic [ADDR_USED_W-1:0] rd_addr,
  input  logic [NCH-1:0]         lock_in,
  output logic [NCH*MODE_W-1:0]  mode_bits,
  output logic [DATA_W-1:0]      rd_byte
);

  acc_kind_e       wr_kind, rd_kind;
  logic [CH_W-1:0] wr_ch, rd_ch;
  logic            unused_hi;

  assign wr_kind   = classify(wr_addr, NCH);
  assign rd_kind   = classify(rd_addr, NCH);
  assign wr_ch     = wr_addr[CH_LSB +: CH_W];
  assign rd_ch     = rd_addr[CH_LSB +: CH_W];
  assign unused_hi = ^wr_byte[DATA_W-1:MODE_W];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [MODE_W-1:0] ctl_q, ctl_d;
    logic              ctl_en;

    always_comb begin
      ctl_en = wr_fire && (wr_kind == ACC_CTRL) && (wr_ch == CH_W'(ch));
      ctl_d  = wr_byte[MODE_W-1:0];
    end

    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_en) ctl_q <= ctl_d;
    end

    assign mode_bits[ch*MODE_W +: MODE_W] = ctl_q;
  end

  always_comb begin
    rd_byte = '0;
    case (rd_kind)
      ACC_CTRL: rd_byte = DATA_W'(mode_bits[rd_ch*MODE_W +: MODE_W]);
      ACC_STAT: rd_byte = DATA_W'(lock_in[rd_ch]);
      default:  rd_byte = '0;
    endcase
  end

endmodule

// File: rtl/sci_rd_shift.sv
module sci_rd_shift
  import sci_pkg::*;
(
  input  logic              sclk,
  input  logic              frame_rst_n,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              rd,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              sdo_bit,
  output logic              sdo_oe
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sh_en;
  logic              oe_q, oe_d;
  logic              in_win, load;

  always_comb begin
    in_win = (bit_cnt >= CNT_W'(HDR_LEN)) && (bit_cnt <= CNT_W'(FRAME_LEN - 1));
    load   = rd && (bit_cnt == CNT_W'(HDR_LEN));
    sh_en  = rd && in_win;
    sh_d   = load ? rd_byte : {1'b0, sh_q[DATA_W-1:1]};
    oe_d   = rd && in_win;
  end

  always_ff @(negedge sclk or negedge frame_rst_n) begin
    if (!frame_rst_n) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else begin
      if (sh_en) sh_q <= sh_d;
      oe_q <= oe_d;
    end
  end

  assign sdo_bit = sh_q[0];
  assign sdo_oe  = oe_q;

endmodule

// File: rtl/sci_regbank.sv
module sci_regbank
  import sci_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int MODE_W = 6
) (
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  sdi,
  input  logic [NCH-1:0]        lock_in,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic [NCH*MODE_W-1:0] mode_bits
);

  logic              frame_rst_n;
  logic [CNT_W-1:0]  bit_cnt;
  frame_hdr_t        hdr;
  logic              hdr_rd;
  logic [DATA_W-1:0] wr_byte;
  logic              wr_fire;
  logic [DATA_W-1:0] rd_byte;
  logic              sdo_bit;

  assign frame_rst_n = rst_n & ~cs_n;
  assign hdr_rd      = hdr.rd;

  sci_frame_ctr u_frame (
    .sclk        (sclk),
    .frame_rst_n (frame_rst_n),
    .sdi         (sdi),
    .bit_cnt     (bit_cnt),
    .hdr         (hdr),
    .wr_byte     (wr_byte),
    .wr_fire     (wr_fire)
  );

  sci_regfile #(.NCH(NCH), .MODE_W(MODE_W)) u_regs (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .wr_addr   (hdr.addr),
    .wr_byte   (wr_byte),
    .rd_addr   (hdr.addr),
    .lock_in   (lock_in),
    .mode_bits (mode_bits),
    .rd_byte   (rd_byte)
  );

  sci_rd_shift u_rdsh (
    .sclk        (sclk),
    .frame_rst_n (frame_rst_n),
    .bit_cnt     (bit_cnt),
    .rd          (hdr_rd),
    .rd_byte     (rd_byte),
    .sdo_bit     (sdo_bit),
    .sdo_oe      (sdo_oe)
  );

  assign sdo = sdo_oe ? sdo_bit : 1'bz;

endmodule

// File: rtl/sci_regbank_chk.sv
module sci_regbank_chk
  import sci_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int MODE_W = 6
) (
  input logic                  sclk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  sdo_oe,
  input logic [NCH*MODE_W-1:0] mode_bits,
  input logic [CNT_W-1:0]      bit_cnt,
  input logic                  hdr_rd
);

  // R1: reset holds the bank clear
  a_r1_reset_clears: assert property (@(posedge sclk)
    !rst_n |-> (mode_bits == '0));

  // R10: driver only while selected
  a_r10_oe_needs_cs: assert property (@(posedge sclk) disable iff (!rst_n)
    sdo_oe |-> !cs_n);

  // R10: driver never on in a write frame
  a_r10_oe_read_only: assert property (@(posedge sclk) disable iff (!rst_n)
    sdo_oe |-> hdr_rd);

  // R7: driver confined to the data phase
  a_r7_oe_window: assert property (@(posedge sclk) disable iff (!rst_n)
    sdo_oe |-> ((bit_cnt >= CNT_W'(HDR_LEN)) && (bit_cnt <= CNT_W'(FRAME_LEN - 1))));

  // R3: control registers move only on the final edge of a frame
  a_r3_commit_only_at_end: assert property (@(posedge sclk) disable iff (!rst_n)
    (bit_cnt != CNT_W'(FRAME_LEN - 1)) |=> $stable(mode_bits));

endmodule

bind sci_regbank sci_regbank_chk #(.NCH(NCH), .MODE_W(MODE_W)) u_chk (
  .sclk      (sclk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sdo_oe    (sdo_oe),
  .mode_bits (mode_bits),
  .bit_cnt   (bit_cnt),
  .hdr_rd    (hdr_rd)
);

// File: tb/test_sci_regbank.sv
module test_sci_regbank;

  localparam int NCH    = 4;
  localparam int MODE_W = 6;

  logic                  rst_n, sclk, cs_n, sdi;
  logic [NCH-1:0]        lock_in;
  wire                   sdo;
  logic                  sdo_oe;
  logic [NCH*MODE_W-1:0] mode_bits;

  int checks = 0;
  int errors = 0;

  logic [MODE_W-1:0] ctrl_m [NCH];
  logic [7:0]        exp_q [$];
  string             req_q [$];

  sci_regbank #(.NCH(NCH), .MODE_W(MODE_W)) i_sci_regbank (
    .rst_n     (rst_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sdi       (sdi),
    .lock_in   (lock_in),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .mode_bits (mode_bits)
  );

  initial sclk = 1'b0;
  always #5 sclk = ~sclk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NCH*MODE_W-1:0] packed_model();
    logic [NCH*MODE_W-1:0] r;
    r = '0;
    for (int c = 0; c < NCH; c++) r[c*MODE_W +: MODE_W] = ctrl_m[c];
    return r;
  endfunction

  function automatic logic [7:0] model_read(input logic [6:0] a);
    int c;
    c = int'(a[4:3]);
    if (a[5] || c >= NCH) return 8'h00;
    if (a[2:0] == 3'd6) return {2'b00, ctrl_m[c]};
    if (a[2:0] == 3'd7) return {7'b0, lock_in[c]};
    return 8'h00;
  endfunction

  // Driver: one frame, possibly cut short after nbits clocks.
  task automatic frame(input bit rd, input logic [6:0] addr, input logic [7:0] dat,
                       input int nbits, input string req);
    logic [15:0] b;
    b = {dat, addr, rd};
    if (rd && nbits == 16) begin
      exp_q.push_back(model_read(addr));
      req_q.push_back(req);
    end
    @(negedge sclk);
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sdi = b[i];
      @(posedge sclk);
      #1;
      if (rd && i == 7) check(sdo_oe == 1'b0, "R7 oe before launch", 32'(sdo_oe), 0);
      if (rd && i == 8) check(sdo_oe == 1'b1, "R7 oe after launch", 32'(sdo_oe), 1);
      if (!rd && (i == 8 || i == 15))
        check(sdo_oe == 1'b0, "R10 oe in write", 32'(sdo_oe), 0);
      @(negedge sclk);
    end
    #1;
    if (rd && nbits == 16) check(sdo_oe == 1'b0, "R7 oe off after frame", 32'(sdo_oe), 0);
    cs_n = 1'b1;
    sdi  = 1'b0;
    #1;
    check(sdo_oe == 1'b0, "R10 oe deselected", 32'(sdo_oe), 0);
    if (!rd && nbits == 16 && !addr[5] && int'(addr[4:3]) < NCH && addr[2:0] == 3'd6)
      ctrl_m[addr[4:3]] = dat[MODE_W-1:0];
    check(mode_bits == packed_model(), req, 32'(mode_bits), 32'(packed_model()));
  endtask

  // Monitor: gathers read bits and scores them against the queue.
  initial begin
    logic [7:0] acc;
    int nb;
    acc = '0;
    nb  = 0;
    forever begin
      @(posedge sclk);
      #1;
      if (cs_n) nb = 0;
      else if (sdo_oe) begin
        acc[nb] = sdo;
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) check(1'b0, "R7 unexpected read", 32'(acc), 0);
          else begin
            logic [7:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(acc == e, r, 32'(acc), 32'(e));
          end
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) ctrl_m[c] = '0;
    rst_n   = 1'b1;
    cs_n    = 1'b1;
    sdi     = 1'b0;
    lock_in = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge sclk);
    #1;
    check(mode_bits == '0, "R1 mode reset", 32'(mode_bits), 0);
    check(sdo_oe == 1'b0, "R1 oe reset", 32'(sdo_oe), 0);
    @(negedge sclk);
    rst_n = 1'b1;

    // R2: program each channel, D7:D6 set in two cases
    frame(1'b0, 7'h06, 8'hFF, 16, "R2 write ch0");
    frame(1'b0, 7'h0E, 8'h15, 16, "R2 write ch1");
    frame(1'b0, 7'h16, 8'h2A, 16, "R2 write ch2");
    frame(1'b0, 7'h1E, 8'hC9, 16, "R2 write ch3");
    frame(1'b1, 7'h06, 8'h00, 16, "R2 read ch0");
    frame(1'b1, 7'h0E, 8'h00, 16, "R2 read ch1");
    frame(1'b1, 7'h16, 8'h00, 16, "R2 read ch2");
    frame(1'b1, 7'h1E, 8'h00, 16, "R2 read ch3");

    // R8: status slots follow lock inputs
    lock_in = 4'b1010;
    frame(1'b1, 7'h07, 8'h00, 16, "R8 status ch0");
    frame(1'b1, 7'h0F, 8'h00, 16, "R8 status ch1");
    frame(1'b1, 7'h17, 8'h00, 16, "R8 status ch2");
    frame(1'b1, 7'h1F, 8'h00, 16, "R8 status ch3");
    lock_in = 4'b0101;
    frame(1'b1, 7'h07, 8'h00, 16, "R8 status ch0 set");

    // R6: writes to status or unmapped slots are dropped
    frame(1'b0, 7'h07, 8'hFF, 16, "R6 write status");
    frame(1'b0, 7'h00, 8'hFF, 16, "R6 write slot0");
    frame(1'b0, 7'h0D, 8'h00, 16, "R6 write slot5");
    frame(1'b1, 7'h06, 8'h00, 16, "R6 ch0 kept");

    // R9: unmapped reads
    frame(1'b1, 7'h05, 8'h00, 16, "R9 read slot5");
    frame(1'b1, 7'h00, 8'h00, 16, "R9 read slot0");
    frame(1'b1, 7'h1C, 8'h00, 16, "R9 read slot4");

    // R4: A5 set blocks both directions
    frame(1'b0, 7'h26, 8'h00, 16, "R4 write a5");
    frame(1'b1, 7'h26, 8'h00, 16, "R4 read a5 ctrl");
    frame(1'b1, 7'h27, 8'h00, 16, "R4 read a5 status");

    // R5: A6 ignored
    frame(1'b0, 7'h46, 8'h11, 16, "R5 write a6");
    frame(1'b1, 7'h4E, 8'h00, 16, "R5 read a6");

    // R3: aborted writes leave state, recovery afterwards
    frame(1'b0, 7'h0E, 8'h00, 15, "R3 abort at 15");
    frame(1'b0, 7'h0E, 8'h00, 12, "R3 abort at 12");
    frame(1'b1, 7'h0E, 8'h00, 16, "R3 read after abort");
    frame(1'b0, 7'h0E, 8'h3C, 16, "R3 write after abort");
    frame(1'b1, 7'h0E, 8'h00, 16, "R3 read after recovery");

    repeat (4) @(posedge sclk);
    #1;
    check(exp_q.size() == 0, "R7 all reads delivered", 32'(exp_q.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule